// File: doc/BRIEF.md
# Asynchronous DRAM Access Sequencer

This block sits between a clocked host and a conventional asynchronous DRAM of 256K eight-bit words. The host presents one request at a time: a word address, a write flag, write data and a flag that asks to leave the row open afterwards. The sequencer then plays out the strobe protocol on the memory pins. It sends the row half of the address with a falling row strobe, the column half with a falling column strobe, and an output-enable or write-enable placed early or late as configured. It returns read data with a one-cycle valid pulse.

All strobe-to-strobe intervals are counted in clock cycles. Row setup, row hold, column setup, column low width, access time from each strobe, row cycle time, precharge and page cycle time are parameters. Two saturating counters track the cycles since the last row-strobe fall and since the last column-strobe fall. These counters gate the transitions that are bound by access and cycle times.

When a request asks to keep the row open, the row strobe stays low afterwards. A following request to the same row is served by a column strobe pulse alone. A request to another row first closes the open row and waits out precharge.

Top module: `dram_seq`

## Requirements
- R1: After reset, req_ready is 1 and mem_ras_n, mem_cas_n, mem_we_n and mem_oe_n are all 1.
- R2: The address is split as row = req_addr[17:9] and column = req_addr[8:0]. mem_addr carries the row when mem_ras_n falls and the column when mem_cas_n falls. mem_addr holds the same value in the cycle before and the cycle after each of those falls. mem_cas_n is low only while mem_ras_n is low.
- R3: The sequencer drives mem_dq only while mem_we_n is 0 and mem_oe_n is 1. mem_oe_n and mem_we_n are never 0 together.
- R4: For a read with cfg_late_rd = 0, mem_oe_n is already 0 when mem_cas_n falls. With cfg_late_rd = 1, mem_oe_n is still 1 when mem_cas_n falls and goes low afterwards. Both styles return the stored byte.
- R5: For a write with cfg_late_wr = 0, mem_we_n is already 0 when mem_cas_n falls. With cfg_late_wr = 1, it is still 1 at that moment and goes low afterwards. In both styles req_wdata reaches the addressed word.
- R6: rsp_valid is a one-cycle pulse. It comes no sooner than T_RAC cycles after the row strobe fell and T_CAC cycles after the column strobe fell. It coincides with the column strobe rising, and rsp_rdata then holds the byte read.
- R7: Successive falls of mem_ras_n are at least T_RC cycles apart. mem_ras_n stays high for at least T_RP cycles before each fall.
- R8: With req_keep_open = 1, mem_ras_n stays low after the access. A following request to the same row produces a new column strobe but no new row strobe. Column strobe falls are at least T_PC cycles apart.
- R9: A request to a different row while a row is open closes the row, waits out precharge, opens the new row and completes there.
- R10: req_ready drops in the cycle after a request is accepted. It returns only when the access is finished and, if the row was closed, precharge has elapsed. While req_ready is 1, the column strobe, output enable, write enable and bus drive are all inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_late_rd | input | 1 | 1 selects late output-enable for reads |
| cfg_late_wr | input | 1 | 1 selects late write-enable for writes |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_keep_open | input | 1 | Leave the row open after this access |
| req_addr | input | 18 | Word address, row in the upper nine bits |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Sequencer can accept a request |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 8 | Read data |
| mem_addr | output | 9 | Multiplexed row/column address |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_cas_n | output | 1 | Column strobe, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_dq | inout | 8 | Shared data bus |

## Verification
The bench runs every pairing of early and late read and write placement. A sequencer that placed an enable on the wrong side of the column strobe fails the ordering check at the strobe fall. Late reads also come back with a released bus instead of the stored byte. Page bursts and an open-row miss are counted by row strobe falls: a design that reopened the row on a hit, or kept it open on a miss, shows the wrong count or reads the wrong row. Distances between strobe falls and from each fall to the read pulse expose any gate that releases a cycle too early.

// File: rtl/dram_seq_pkg.sv
package dram_seq_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ROW_SU,
        S_ROW_HOLD,
        S_COL_SU,
        S_CAS,
        S_ACC,
        S_OPEN,
        S_PRE
    } seq_state_e;
endpackage

// File: rtl/dram_seq_age.sv
module dram_seq_age #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] age
);
    localparam logic [W-1:0] MAX = '1;

    logic [W-1:0] age_d, age_q;

    always_comb begin
        if (clr)             age_d = '0;
        else if (age_q == MAX) age_d = MAX;
        else                 age_d = age_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) age_q <= MAX;
        else        age_q <= age_d;
    end

    assign age = age_q;
endmodule

// File: rtl/dram_seq.sv
module dram_seq
    import dram_seq_pkg::*;
#(
    parameter int ROW_W  = 9,
    parameter int COL_W  = 9,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 6,
    parameter int T_ASR  = 1,
    parameter int T_RAH  = 2,
    parameter int T_ASC  = 1,
    parameter int T_CAH  = 3,
    parameter int T_CAC  = 4,
    parameter int T_RAC  = 15,
    parameter int T_RC   = 28,
    parameter int T_PC   = 9,
    parameter int T_RP   = 10
) (
    input  logic                                    clk,
    input  logic                                    rst_n,
    input  logic                                    cfg_late_rd,
    input  logic                                    cfg_late_wr,
    input  logic                                    req_valid,
    input  logic                                    req_write,
    input  logic                                    req_keep_open,
    input  logic [ROW_W+COL_W-1:0]                  req_addr,
    input  logic [DATA_W-1:0]                       req_wdata,
    output logic                                    req_ready,
    output logic                                    rsp_valid,
    output logic [DATA_W-1:0]                       rsp_rdata,
    output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] mem_addr,
    output logic                                    mem_ras_n,
    output logic                                    mem_cas_n,
    output logic                                    mem_we_n,
    output logic                                    mem_oe_n,
    inout  wire  [DATA_W-1:0]                       mem_dq
);
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int MA_W   = (ROW_W > COL_W) ? ROW_W : COL_W;

    // Count reload values: a state lasts (reload + 1) cycles
    localparam logic [CNT_W-1:0] C_ASR = CNT_W'(T_ASR - 1);
    localparam logic [CNT_W-1:0] C_RAH = CNT_W'(T_RAH - 1);
    localparam logic [CNT_W-1:0] C_ASC = CNT_W'(T_ASC - 1);
    localparam logic [CNT_W-1:0] C_CAH = CNT_W'(T_CAH - 1);
    localparam logic [CNT_W-1:0] C_RP  = CNT_W'(T_RP - 1);
    // Age thresholds: strobe may move on the edge after age reaches these
    localparam logic [CNT_W-1:0] A_CAC = CNT_W'(T_CAC - 1);
    localparam logic [CNT_W-1:0] A_RAC = CNT_W'(T_RAC - 1);
    localparam logic [CNT_W-1:0] A_RC  = CNT_W'(T_RC - 1);
    localparam logic [CNT_W-1:0] A_PC  = CNT_W'(T_PC - 1);

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [MA_W-1:0]   ma;
        logic              ras_n;
        logic              cas_n;
        logic              we_n;
        logic              oe_n;
        logic              drv;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic              keep;
        logic              pend;
        logic              rdy;
        logic              rvld;
        logic [DATA_W-1:0] wd;
        logic [DATA_W-1:0] rd;
    } seq_t;

    localparam seq_t RST = '{st: S_IDLE, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                             oe_n: 1'b1, rdy: 1'b1, default: '0};

    seq_t q, d;
    logic [CNT_W-1:0] ras_age, cas_age;
    logic             col_go;
    logic             cnt_done;
    logic             acc;
    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             dq_drive;

    assign req_row = req_addr[ADDR_W-1:COL_W];
    assign req_col = req_addr[COL_W-1:0];

    dram_seq_age #(.W(CNT_W)) u_ras_age (
        .clk(clk), .rst_n(rst_n), .clr(q.ras_n && !d.ras_n), .age(ras_age)
    );
    dram_seq_age #(.W(CNT_W)) u_cas_age (
        .clk(clk), .rst_n(rst_n), .clr(q.cas_n && !d.cas_n), .age(cas_age)
    );

    always_comb begin
        d        = q;
        d.rvld   = 1'b0;
        col_go   = 1'b0;
        acc      = req_valid && q.rdy;
        cnt_done = (q.cnt == '0);
        if (!cnt_done) d.cnt = q.cnt - 1'b1;

        case (q.st)
            S_IDLE: if (acc) begin
                d.row  = req_row;
                d.col  = req_col;
                d.wr   = req_write;
                d.keep = req_keep_open;
                d.wd   = req_wdata;
                d.rdy  = 1'b0;
                d.ma   = MA_W'(req_row);
                d.cnt  = C_ASR;
                d.st   = S_ROW_SU;
            end
            S_ROW_SU: if (cnt_done && ras_age >= A_RC) begin
                d.ras_n = 1'b0;
                d.cnt   = C_RAH;
                d.st    = S_ROW_HOLD;
            end
            S_ROW_HOLD: if (cnt_done) col_go = 1'b1;
            S_COL_SU: if (cnt_done && cas_age >= A_PC) begin
                d.cas_n = 1'b0;
                d.cnt   = C_CAH;
                d.st    = S_CAS;
            end
            S_CAS: if (cnt_done) begin
                d.st = S_ACC;
                if (q.wr && cfg_late_wr) begin
                    d.we_n = 1'b0;
                    d.drv  = 1'b1;
                end
                if (!q.wr && cfg_late_rd) d.oe_n = 1'b0;
            end
            S_ACC: if (ras_age >= A_RAC && cas_age >= A_CAC) begin
                if (!q.wr) begin
                    d.rd   = mem_dq;
                    d.rvld = 1'b1;
                end
                d.cas_n = 1'b1;
                d.oe_n  = 1'b1;
                d.we_n  = 1'b1;
                d.drv   = 1'b0;
                if (q.keep) begin
                    d.st  = S_OPEN;
                    d.rdy = 1'b1;
                end else begin
                    d.ras_n = 1'b1;
                    d.cnt   = C_RP;
                    d.st    = S_PRE;
                end
            end
            S_OPEN: if (acc) begin
                d.col  = req_col;
                d.wr   = req_write;
                d.keep = req_keep_open;
                d.wd   = req_wdata;
                d.rdy  = 1'b0;
                if (req_row == q.row) begin
                    col_go = 1'b1;
                end else begin
                    d.row   = req_row;
                    d.pend  = 1'b1;
                    d.ras_n = 1'b1;
                    d.cnt   = C_RP;
                    d.st    = S_PRE;
                end
            end
            S_PRE: if (cnt_done) begin
                if (q.pend) begin
                    d.pend = 1'b0;
                    d.ma   = MA_W'(q.row);
                    d.cnt  = C_ASR;
                    d.st   = S_ROW_SU;
                end else begin
                    d.rdy = 1'b1;
                    d.st  = S_IDLE;
                end
            end
            default: d = RST;
        endcase

        // Column phase entry: present column, place early enables
        if (col_go) begin
            d.ma  = MA_W'(d.col);
            d.cnt = C_ASC;
            d.st  = S_COL_SU;
            if (d.wr && !cfg_late_wr) begin
                d.we_n = 1'b0;
                d.drv  = 1'b1;
            end
            if (!d.wr && !cfg_late_rd) d.oe_n = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= RST;
        else        q <= d;
    end

    assign dq_drive  = q.drv;
    assign mem_dq    = dq_drive ? q.wd : 'z;
    assign req_ready = q.rdy;
    assign rsp_valid = q.rvld;
    assign rsp_rdata = q.rd;
    assign mem_addr  = q.ma;
    assign mem_ras_n = q.ras_n;
    assign mem_cas_n = q.cas_n;
    assign mem_we_n  = q.we_n;
    assign mem_oe_n  = q.oe_n;
endmodule

// File: rtl/dram_seq_chk.sv
module dram_seq_chk #(
    parameter int MA_W = 9
) (
    input logic            clk,
    input logic            rst_n,
    input logic            ras_n,
    input logic            cas_n,
    input logic            we_n,
    input logic            oe_n,
    input logic            drv,
    input logic            ready,
    input logic            rvld,
    input logic [MA_W-1:0] ma
);
    AST_BUS_ONLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        drv |-> (!we_n && oe_n)); // R3
    AST_NO_OE_WE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n || we_n)); // R3
    AST_CAS_IN_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n); // R2
    AST_ROW_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> $stable(ma)); // R2
    AST_COL_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $stable(ma)); // R2
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (cas_n && oe_n && we_n && !drv)); // R10
    AST_RVLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rvld |=> !rvld); // R6
    AST_RVLD_AT_CAS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rvld |-> $rose(cas_n)); // R6
endmodule

bind dram_seq dram_seq_chk #(.MA_W(MA_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .ras_n (mem_ras_n),
    .cas_n (mem_cas_n),
    .we_n  (mem_we_n),
    .oe_n  (mem_oe_n),
    .drv   (dq_drive),
    .ready (req_ready),
    .rvld  (rsp_valid),
    .ma    (mem_addr)
);

// File: tb/sim_dram_seq.sv
`timescale 1ns/1ps
module sim_dram_seq;
    localparam int T_CAC = 4;
    localparam int T_RAC = 15;
    localparam int T_RC  = 28;
    localparam int T_PC  = 9;
    localparam int T_RP  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        late_rd = 1'b0, late_wr = 1'b0;
    logic        valid = 1'b0, wr = 1'b0, keep = 1'b0;
    logic [17:0] addr = '0;
    logic [7:0]  wdata = '0;
    wire         ready, rvld;
    wire  [7:0]  rdata;
    wire  [8:0]  ma;
    wire         ras_n, cas_n, we_n, oe_n;
    wire  [7:0]  dq;

    dram_seq #(.T_CAC(T_CAC), .T_RAC(T_RAC), .T_RC(T_RC), .T_PC(T_PC), .T_RP(T_RP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_late_rd(late_rd), .cfg_late_wr(late_wr),
        .req_valid(valid), .req_write(wr), .req_keep_open(keep), .req_addr(addr),
        .req_wdata(wdata), .req_ready(ready), .rsp_valid(rvld), .rsp_rdata(rdata),
        .mem_addr(ma), .mem_ras_n(ras_n), .mem_cas_n(cas_n), .mem_we_n(we_n),
        .mem_oe_n(oe_n), .mem_dq(dq)
    );

    int checks = 0, errors = 0;

    // Memory model: row latched on ras fall, column on cas fall
    logic [7:0] mem     [0:1023];
    logic [7:0] ref_mem [0:1023];
    logic [8:0] m_row = '0, m_col = '0;

    function automatic logic [9:0] idx(input logic [8:0] r, input logic [8:0] c);
        return {r[4:0], c[4:0]};
    endfunction

    assign dq = (!oe_n && we_n && !cas_n) ? mem[idx(m_row, m_col)] : 8'bz;

    logic [7:0]  exp_q[$];
    logic        cur_wr = 1'b0;
    logic [17:0] cur_addr = '0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: protocol order, timing distances and scoreboard pop
    logic p_ras = 1'b1, p_cas = 1'b1;
    int   ras_cnt = 1000, cas_cnt = 1000, hi_cnt = 1000, ras_falls = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            ras_cnt++; cas_cnt++; hi_cnt++;
            if (!p_ras && ras_n) hi_cnt = 0;
            if (p_ras && !ras_n) begin
                chk(ras_cnt >= T_RC, "R7 row cycle", ras_cnt, T_RC);
                chk(hi_cnt >= T_RP, "R7 precharge", hi_cnt, T_RP);
                chk(ma == cur_addr[17:9], "R2 row address", int'(ma), int'(cur_addr[17:9]));
                m_row = ma;
                ras_cnt = 0;
                ras_falls++;
            end
            if (p_cas && !cas_n) begin
                chk(cas_cnt >= T_PC, "R8 page cycle", cas_cnt, T_PC);
                chk(ma == cur_addr[8:0], "R2 column address", int'(ma), int'(cur_addr[8:0]));
                if (cur_wr) chk(we_n == late_wr, "R5 write enable placement", int'(we_n), int'(late_wr));
                else        chk(oe_n == late_rd, "R4 output enable placement", int'(oe_n), int'(late_rd));
                m_col = ma;
                cas_cnt = 0;
            end
            if (!ras_n && !cas_n && !we_n) mem[idx(m_row, m_col)] = dq;
            if (rvld) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected read pulse", 1, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    chk(rdata == e, "R6 read data", int'(rdata), int'(e));
                end
                chk(ras_cnt >= T_RAC, "R6 access from row strobe", ras_cnt, T_RAC);
                chk(cas_cnt >= T_CAC, "R6 access from column strobe", cas_cnt, T_CAC);
            end
            p_ras = ras_n;
            p_cas = cas_n;
        end
    end

    // Driver: issue one request, push expected read data
    task automatic req(input bit w, input logic [8:0] r, input logic [8:0] c,
                       input logic [7:0] dat, input bit kp);
        @(negedge clk);
        while (!ready) @(negedge clk);
        cur_wr = w; cur_addr = {r, c};
        valid = 1'b1; wr = w; addr = {r, c}; wdata = dat; keep = kp;
        if (w) ref_mem[idx(r, c)] = dat;
        else   exp_q.push_back(ref_mem[idx(r, c)]);
        @(negedge clk);
        valid = 1'b0;
        chk(!ready, "R10 ready drops after accept", int'(ready), 0);
    endtask

    task automatic drain();
        @(negedge clk);
        while (!ready || exp_q.size() != 0) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int base;
        for (int i = 0; i < 1024; i++) begin
            mem[i]     = 8'h80 | 8'(i % 128);
            ref_mem[i] = 8'h80 | 8'(i % 128);
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(ready == 1'b1, "R1 ready after reset", int'(ready), 1);
        chk(ras_n == 1'b1, "R1 ras idle", int'(ras_n), 1);
        chk(cas_n == 1'b1, "R1 cas idle", int'(cas_n), 1);
        chk(we_n == 1'b1, "R1 we idle", int'(we_n), 1);
        chk(oe_n == 1'b1, "R1 oe idle", int'(oe_n), 1);
        rst_n = 1'b1;

        // Early read, early write (R4, R5)
        late_rd = 1'b0; late_wr = 1'b0;
        req(1'b1, 9'd3, 9'd5, 8'h12, 1'b0);
        req(1'b0, 9'd3, 9'd5, 8'h00, 1'b0);
        req(1'b1, 9'd7, 9'd9, 8'hA5, 1'b0);
        req(1'b0, 9'd7, 9'd9, 8'h00, 1'b0);
        req(1'b0, 9'd1, 9'd2, 8'h00, 1'b0);
        drain();

        // Late read, late write (R4, R5)
        late_rd = 1'b1; late_wr = 1'b1;
        req(1'b1, 9'd3, 9'd6, 8'h3C, 1'b0);
        req(1'b0, 9'd3, 9'd6, 8'h00, 1'b0);
        req(1'b0, 9'd7, 9'd9, 8'h00, 1'b0);
        drain();

        // Mixed: early read, late write
        late_rd = 1'b0; late_wr = 1'b1;
        req(1'b1, 9'd12, 9'd20, 8'h5A, 1'b0);
        req(1'b0, 9'd12, 9'd20, 8'h00, 1'b0);
        drain();

        // R8 page burst in one row, late read, early write
        late_rd = 1'b1; late_wr = 1'b0;
        base = ras_falls;
        req(1'b1, 9'd10, 9'd1, 8'h61, 1'b1);
        req(1'b1, 9'd10, 9'd2, 8'h62, 1'b1);
        req(1'b0, 9'd10, 9'd1, 8'h00, 1'b1);
        req(1'b0, 9'd10, 9'd2, 8'h00, 1'b0);
        drain();
        chk(ras_falls - base == 1, "R8 one row strobe per burst", ras_falls - base, 1);

        // R9 open-row miss
        base = ras_falls;
        req(1'b0, 9'd10, 9'd2, 8'h00, 1'b1);
        req(1'b0, 9'd3, 9'd6, 8'h00, 1'b0);
        drain();
        chk(ras_falls - base == 2, "R9 row reopened on miss", ras_falls - base, 2);

        chk(ready == 1'b1, "R10 ready after precharge", int'(ready), 1);
        chk(exp_q.size() == 0, "R6 all reads returned", exp_q.size(), 0);
        finish_run();
    end
endmodule